// File: doc/BRIEF.md
# Rolling Shutter Row Sequencer

This block steps a 64-row by 128-column pixel matrix through row-wise readout with correlated double sampling. Each row is handled on its own. The sequencer turns the row's gate line on and keeps it on. After a programmable settle time it strobes the column digitisers for a first sample, which holds signal plus pedestal. It then pulses that row's clear line and waits a programmable settle time. Next it strobes a second sample, which holds pedestal only. One cycle later it tells the subtraction path that both samples of the row are ready. It then moves on to the next row.

No whole frame is ever buffered, because the second sample of a row serves as that row's own pedestal reference. The pixels collect charge while their row is off, so there is no global reset phase. Readout rolls from row 63 back to row 0 without a break.

A start pulse begins continuous rolling. A trigger pulse runs exactly one frame. A stop pulse lets the current row finish and then parks the sequencer. The three phase lengths are cycle counts. With every length at its minimum, the first strobe and the second strobe are three clock cycles apart.

Top module: `row_seq`

## Requirements
- R1: After reset, busy_o, frame_start_o, every gate and clear line and every strobe are low, and row_o is 0.
- R2: At most one gate line is ever high. While busy, the line selected by row_o is high for the whole row period. While idle, no gate line is high.
- R3: A row with gate length G, clear length C and settle length S lasts G+C+S+3 cycles, counted from its first gate cycle at offset 0. The phases are:
  - offsets 0 to G-1: gate on only;
  - offset G: smp_stb_o is high with smp_second_o=0;
  - offsets G+1 to G+C: the row's clear line is high;
  - the next S cycles: settle, with no strobe and no clear;
  - offset G+C+S+1: smp_stb_o is high with smp_second_o=1;
  - the final offset: sub_stb_o is high.
- R4: A phase length of 0 is treated as 1.
- R5: After sub_stb_o the row index rises by 1, and it wraps from 63 to 0. frame_start_o is high for exactly one cycle, on the first gate cycle of every row 0.
- R6: A start_i pulse while idle begins continuous readout at row 0. A trig_i pulse while idle reads rows 0 to 63 once and then goes idle. If both pulses come together, start_i wins.
- R7: A stop_i pulse at any cycle of a row lets that row complete through its sub_stb_o cycle. The sequencer then goes idle, with busy_o low and every gate and clear line low.
- R8: start_i and trig_i have no effect while busy. A stop_i pulse while idle has no effect on the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin continuous readout (pulse) |
| trig_i | input | 1 | Read one frame (pulse) |
| stop_i | input | 1 | Halt after the current row (pulse) |
| gate_len_i | input | 8 | Gate settle cycles before the first sample |
| clr_len_i | input | 8 | Clear pulse cycles |
| settle_len_i | input | 8 | Settle cycles after clear before the second sample |
| busy_o | output | 1 | Sequencer active |
| frame_start_o | output | 1 | One-cycle marker on the first gate cycle of row 0 |
| gate_o | output | 64 | One-hot row gate select |
| clear_o | output | 64 | Row clear lines |
| smp_stb_o | output | 1 | Column sample strobe |
| smp_second_o | output | 1 | Strobe is the second (pedestal-only) sample |
| sub_stb_o | output | 1 | Both samples of the row are valid |
| row_o | output | 6 | Row index carried with the strobes |

## Verification
The cases that are hardest to reach are these:
- a stop arriving in the very last cycle of a row;
- start and trigger pulses arriving in the middle of a continuous frame;
- the wrap from row 63 back to row 0.

The last one can only be seen after a complete frame of row cycles. The directed stimulus times each pulse to a chosen cycle offset inside a chosen row. A checking task then compares every cycle of that row against the phase layout computed from the lengths that were programmed. Continuous runs are followed past row 63 into the next row 0, so that both the wrap and the repeated frame marker are observed.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE,
    ST_SMP1,
    ST_CLEAR,
    ST_SETTLE,
    ST_SMP2,
    ST_SUB
  } seq_state_e;
endpackage

// File: rtl/row_seq_timer.sv
module row_seq_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LEN_W'(1);
    end else if (load_i) begin
      cnt_q <= (len_i == '0) ? LEN_W'(1) : len_i; // zero clamps to one
    end else if (cnt_q > LEN_W'(1)) begin
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  assign done_o = (cnt_q == LEN_W'(1));
endmodule

// File: rtl/row_seq_ctrl.sv
module row_seq_ctrl
  import row_seq_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int LEN_W = 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             trig_i,
  input  logic             stop_i,
  input  logic [LEN_W-1:0] gate_len_i,
  input  logic [LEN_W-1:0] clr_len_i,
  input  logic [LEN_W-1:0] settle_len_i,
  input  logic             done_i,
  output logic             load_o,
  output logic [LEN_W-1:0] len_o,
  output seq_state_e       state_o,
  output logic [ROW_W-1:0] row_o,
  output logic             frame_start_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  seq_state_e       state_q, state_d;
  logic [ROW_W-1:0] row_q;
  logic             single_q, stop_pend_q, frame_q;
  logic             go, adv;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    len_o   = '0;
    go      = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i || trig_i) begin
        state_d = ST_GATE;
        load_o  = 1'b1;
        len_o   = gate_len_i;
        go      = 1'b1;
      end
      ST_GATE: if (done_i) state_d = ST_SMP1;
      ST_SMP1: begin
        state_d = ST_CLEAR;
        load_o  = 1'b1;
        len_o   = clr_len_i;
      end
      ST_CLEAR: if (done_i) begin
        state_d = ST_SETTLE;
        load_o  = 1'b1;
        len_o   = settle_len_i;
      end
      ST_SETTLE: if (done_i) state_d = ST_SMP2;
      ST_SMP2: state_d = ST_SUB;
      ST_SUB: begin
        if (stop_pend_q || stop_i || (single_q && row_q == LAST_ROW)) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_GATE;
          load_o  = 1'b1;
          len_o   = gate_len_i;
          adv     = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      row_q       <= '0;
      single_q    <= 1'b0;
      stop_pend_q <= 1'b0;
      frame_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      frame_q <= go || (adv && row_q == LAST_ROW);
      if (go) begin
        row_q    <= '0;
        single_q <= !start_i;
      end else if (adv) begin
        row_q <= (row_q == LAST_ROW) ? '0 : row_q + ROW_W'(1);
      end
      if (state_d == ST_IDLE)                stop_pend_q <= 1'b0;
      else if (stop_i && state_q != ST_IDLE) stop_pend_q <= 1'b1;
    end
  end

  assign state_o       = state_q;
  assign row_o         = row_q;
  assign frame_start_o = frame_q;
endmodule

// File: rtl/row_seq_decode.sv
module row_seq_decode #(
  parameter int ROWS = 64,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic             gate_en_i,
  input  logic             clear_en_i,
  output logic [ROWS-1:0]  gate_o,
  output logic [ROWS-1:0]  clear_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    assign hit        = (row_i == ROW_W'(r));
    assign gate_o[r]  = hit && gate_en_i;
    assign clear_o[r] = hit && clear_en_i;
  end
endmodule

// File: rtl/row_seq.sv
module row_seq
  import row_seq_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int LEN_W = 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             trig_i,
  input  logic             stop_i,
  input  logic [LEN_W-1:0] gate_len_i,
  input  logic [LEN_W-1:0] clr_len_i,
  input  logic [LEN_W-1:0] settle_len_i,
  output logic             busy_o,
  output logic             frame_start_o,
  output logic [ROWS-1:0]  gate_o,
  output logic [ROWS-1:0]  clear_o,
  output logic             smp_stb_o,
  output logic             smp_second_o,
  output logic             sub_stb_o,
  output logic [ROW_W-1:0] row_o
);
  seq_state_e       state;
  logic             load, done;
  logic [LEN_W-1:0] len;

  row_seq_timer #(.LEN_W(LEN_W)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .len_i (len),
    .done_o(done)
  );

  row_seq_ctrl #(.ROWS(ROWS), .LEN_W(LEN_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .trig_i       (trig_i),
    .stop_i       (stop_i),
    .gate_len_i   (gate_len_i),
    .clr_len_i    (clr_len_i),
    .settle_len_i (settle_len_i),
    .done_i       (done),
    .load_o       (load),
    .len_o        (len),
    .state_o      (state),
    .row_o        (row_o),
    .frame_start_o(frame_start_o)
  );

  assign busy_o       = (state != ST_IDLE);
  assign smp_stb_o    = (state == ST_SMP1) || (state == ST_SMP2);
  assign smp_second_o = (state == ST_SMP2);
  assign sub_stb_o    = (state == ST_SUB);

  row_seq_decode #(.ROWS(ROWS)) i_decode (
    .row_i     (row_o),
    .gate_en_i (busy_o),
    .clear_en_i(state == ST_CLEAR),
    .gate_o    (gate_o),
    .clear_o   (clear_o)
  );
endmodule

// File: rtl/row_seq_chk.sv
module row_seq_chk #(
  parameter int ROWS = 64,
  localparam int ROW_W = $clog2(ROWS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             frame_start_o,
  input logic [ROWS-1:0]  gate_o,
  input logic [ROWS-1:0]  clear_o,
  input logic             smp_stb_o,
  input logic             smp_second_o,
  input logic             sub_stb_o,
  input logic [ROW_W-1:0] row_o
);
  p_one_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gate_o));

  p_clear_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o & ~gate_o) == '0);

  p_sub_after_second_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_stb_o |-> $past(smp_stb_o && smp_second_o));

  p_no_strobe_in_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o != '0) |-> !smp_stb_o && !sub_stb_o);

  p_frame_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  p_frame_row0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> row_o == '0 && gate_o[0]);

  p_row_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && !$past(sub_stb_o) |-> $stable(row_o));

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> gate_o == '0 && clear_o == '0 && !smp_stb_o && !sub_stb_o);
endmodule

bind row_seq row_seq_chk #(.ROWS(ROWS)) i_row_seq_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .frame_start_o(frame_start_o),
  .gate_o       (gate_o),
  .clear_o      (clear_o),
  .smp_stb_o    (smp_stb_o),
  .smp_second_o (smp_second_o),
  .sub_stb_o    (sub_stb_o),
  .row_o        (row_o)
);

// File: tb/test_row_seq.sv
`timescale 1ns/1ps
module test_row_seq;
  localparam int ROWS = 64;
  localparam int ROW_W = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, trig_i = 1'b0, stop_i = 1'b0;
  logic [7:0] gate_len_i = 8'd1, clr_len_i = 8'd1, settle_len_i = 8'd1;
  logic busy_o, frame_start_o, smp_stb_o, smp_second_o, sub_stb_o;
  logic [ROWS-1:0] gate_o, clear_o;
  logic [ROW_W-1:0] row_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  row_seq i_row_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .trig_i(trig_i),
    .stop_i(stop_i), .gate_len_i(gate_len_i), .clr_len_i(clr_len_i),
    .settle_len_i(settle_len_i), .busy_o(busy_o), .frame_start_o(frame_start_o),
    .gate_o(gate_o), .clear_o(clear_o), .smp_stb_o(smp_stb_o),
    .smp_second_o(smp_second_o), .sub_stb_o(sub_stb_o), .row_o(row_o)
  );

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic check_idle(input string req);
    chk(!busy_o && gate_o == '0 && clear_o == '0 && !smp_stb_o && !sub_stb_o
        && !frame_start_o,
        $sformatf("%s idle: busy=%0b gate=%h clear=%h smp=%0b sub=%0b exp all 0",
                  req, busy_o, gate_o, clear_o, smp_stb_o, sub_stb_o));
  endtask

  // Check every cycle of one row; optionally pulse stop or start+trig at an offset.
  task automatic check_row(input int row, input int g, input int c, input int s,
                           input int stop_at, input int inj_at, input string req);
    int gg = (g == 0) ? 1 : g;
    int cc = (c == 0) ? 1 : c;
    int ss = (s == 0) ? 1 : s;
    int per = gg + cc + ss + 3;
    bit ok = 1'b1;
    string msg = "";
    logic [ROWS-1:0] one = '0;
    one[row] = 1'b1;
    for (int i = 0; i < per; i++) begin
      logic [ROWS-1:0] e_clr = (i > gg && i <= gg + cc) ? one : '0;
      bit e_smp = (i == gg) || (i == gg + cc + ss + 1);
      bit e_sec = (i == gg + cc + ss + 1);
      bit e_sub = (i == per - 1);
      bit e_fs  = (row == 0) && (i == 0);
      stop_i  = (i == stop_at);
      start_i = (i == inj_at);
      trig_i  = (i == inj_at);
      if (ok && (!busy_o || gate_o != one || clear_o != e_clr || smp_stb_o != e_smp ||
          (e_smp && smp_second_o != e_sec) || sub_stb_o != e_sub ||
          frame_start_o != e_fs || int'(row_o) != row)) begin
        ok = 1'b0;
        msg = $sformatf("%s row %0d off %0d: gate=%h/%h clr=%h/%h smp=%0b/%0b sec=%0b/%0b sub=%0b/%0b fs=%0b/%0b row=%0d/%0d (act/exp)",
          req, row, i, gate_o, one, clear_o, e_clr, smp_stb_o, e_smp, smp_second_o,
          e_sec, sub_stb_o, e_sub, frame_start_o, e_fs, row_o, row);
      end
      @(negedge clk);
    end
    stop_i = 1'b0; start_i = 1'b0; trig_i = 1'b0;
    chk(ok, msg);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic t_reset;
    chk(row_o == '0, $sformatf("R1 row=%0d exp 0", row_o));
    check_idle("R1");
  endtask

  task automatic t_single_frame;
    gate_len_i = 8'd2; clr_len_i = 8'd1; settle_len_i = 8'd1;
    pulse(trig_i);
    for (int r = 0; r < ROWS; r++) check_row(r, 2, 1, 1, -1, -1, "R3 R5 R6");
    check_idle("R6");
    repeat (5) @(negedge clk);
    check_idle("R6");
  endtask

  task automatic t_zero_len_stop;
    gate_len_i = 8'd0; clr_len_i = 8'd0; settle_len_i = 8'd0;
    pulse(start_i);
    check_row(0, 0, 0, 0, -1, -1, "R4");
    check_row(1, 0, 0, 0, 5, -1, "R4 R7");
    check_idle("R7");
  endtask

  task automatic t_continuous_wrap;
    gate_len_i = 8'd1; clr_len_i = 8'd2; settle_len_i = 8'd3;
    pulse(start_i);
    for (int r = 0; r < ROWS; r++)
      check_row(r, 1, 2, 3, -1, (r == 5) ? 4 : -1, (r == 5) ? "R8" : "R2 R3");
    check_row(0, 1, 2, 3, -1, -1, "R5");
    check_row(1, 1, 2, 3, 0, -1, "R7");
    check_idle("R7");
  endtask

  task automatic t_stop_idle;
    gate_len_i = 8'd3; clr_len_i = 8'd2; settle_len_i = 8'd1;
    pulse(stop_i);
    @(negedge clk);
    check_idle("R8");
    pulse(trig_i);
    check_row(0, 3, 2, 1, -1, -1, "R8");
    check_row(1, 3, 2, 1, -1, -1, "R8");
    check_row(2, 3, 2, 1, 2, -1, "R7");
    check_idle("R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_frame();
    t_zero_len_stop();
    t_continuous_wrap();
    t_stop_idle();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule